// File: doc/BRIEF.md
# Fractional-N PLL Setting Calculator

This block turns a reference clock rate and a wanted output rate into the settings of a fractional-N synthesiser. Software or a configuration controller presents four 32-bit rates in Hz: the reference rate, the wanted output rate, the highest allowed internal comparison rate and the lowest allowed oscillator rate. The caller pulses a start strobe and receives the results after a fixed number of cycles. The results are the reference predivider, the integer and 18-bit fractional feedback multipliers, the post-divider and a sigma-delta code. The block also returns the internal comparison rate, the oscillator rate and the output rate that those settings produce.

All quotients come from one shared bit-serial restoring divider that is 64 bits wide. A small sequencer runs eight divisions in a fixed order and feeds each result into the operands of the next. The products between the divisions fit into the same cycles. The run length therefore does not depend on the operand values. It does not choose between alternative solutions and it does not generate a clock.

Top module: `frac_pll_calc`

## Requirements
- R1: The predivider is ceil(reference / max_internal) and the internal rate is floor(reference / predivider).
- R2: The oscillator minimum is rounded up to the next whole multiple of the internal rate. The post-divider is the ceiling of that value over the wanted output rate, and a result of 0 is replaced by 1.
- R3: The integer multiplier is floor(wanted_output × post-divider / internal). The fraction is floor(2^18 × remainder / internal), where the remainder is wanted_output × post-divider − internal × multiplier. The fraction is 18 bits wide.
- R4: The oscillator rate is internal × multiplier + floor(fraction × internal / 2^18). The output rate is floor(oscillator / post-divider).
- R5: The sigma-delta code is ceil(internal × multiplier / 250,000,000).
- R6: For a valid request, done is high for exactly one cycle, 8 × (64 + 2) + 1 = 529 clock edges after the edge that accepts start. Busy is high from the accepting edge until done rises.
- R7: A start strobe that arrives while busy is high is ignored. The running computation finishes at the same cycle and returns the results of the first operands.
- R8: After done, every result output keeps its value until another start is accepted.
- R9: If the reference, the wanted output or the max-internal rate is 0, every result is 0 and the error flag is 1. Done pulses one edge after the accepting edge.
- R10: After reset, every result output, the error flag, busy and done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, taken only when idle |
| ref_in_i | input | 32 | Reference rate in Hz |
| tgt_out_i | input | 32 | Wanted output rate in Hz |
| fint_max_i | input | 32 | Highest allowed internal comparison rate in Hz |
| dco_min_i | input | 32 | Lowest allowed oscillator rate in Hz |
| busy_o | output | 1 | A computation is running |
| done_o | output | 1 | One-cycle pulse: the results are valid |
| err_o | output | 1 | Zero operand, or the fraction went out of range |
| pre_n_o | output | 32 | Reference predivider |
| mult_m_o | output | 32 | Integer feedback multiplier |
| frac_o | output | 18 | Fractional multiplier, in units of 2^-18 |
| post_m2_o | output | 32 | Post-divider |
| sd_o | output | 32 | Sigma-delta code |
| fint_o | output | 32 | Internal comparison rate in Hz |
| dco_o | output | 64 | Oscillator rate in Hz |
| out_o | output | 32 | Output rate in Hz |

## Verification
A valid request owes its done pulse and all its results at the 529th edge after acceptance. A zero-operand request owes them at the first edge. The bench counts edges from the accepting edge and samples on the falling edge between them. It compares busy and done against a counter-based model on every cycle. It checks every result against the requirement formulas at the done cycle, and again twenty cycles later to test the hold rule. In one run a stray start is injected halfway through, and the bench expects that run's timing and results to be unchanged.

// File: rtl/frac_pll_pkg.sv
package frac_pll_pkg;

   // Sequencer steps; each division step issues one divider run.
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_PREDIV,
      ST_FINT,
      ST_RNDUP,
      ST_POST,
      ST_MULT,
      ST_FRAC,
      ST_OUT,
      ST_SD,
      ST_FIN
   } calc_state_e;

   localparam int unsigned NUM_DIV_STEPS = 8;

endpackage

// File: rtl/frac_pll_divider.sv
module frac_pll_divider #(
   parameter int unsigned DW = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [DW-1:0] dividend_i,
   input  logic [DW-1:0] divisor_i,
   output logic          busy_o,
   output logic          done_o,
   output logic [DW-1:0] quot_o,
   output logic [DW-1:0] rem_o
);
   localparam int unsigned CW = $clog2(DW + 1);

   logic [CW-1:0] cnt_q;
   logic [DW-1:0] rem_q, quo_q, dvs_q;
   logic [DW:0]   shifted, diff;
   logic          ge;

   always_comb begin
      shifted = {rem_q, quo_q[DW-1]};
      diff    = shifted - {1'b0, dvs_q};
      ge      = (shifted >= {1'b0, dvs_q});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         rem_q  <= '0;
         quo_q  <= '0;
         dvs_q  <= '0;
         done_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (start_i && cnt_q == '0) begin
            rem_q <= '0;
            quo_q <= dividend_i;
            dvs_q <= divisor_i;
            cnt_q <= CW'(DW);
         end else if (cnt_q != '0) begin
            rem_q <= ge ? diff[DW-1:0] : shifted[DW-1:0];
            quo_q <= {quo_q[DW-2:0], ge};
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) done_o <= 1'b1;
         end
      end
   end

   assign busy_o = (cnt_q != '0);
   assign quot_o = quo_q;
   assign rem_o  = rem_q;

   // A finished division leaves a remainder below its divisor.
   p_rem_below_divisor_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && dvs_q != '0) |-> (rem_o < dvs_q));

endmodule

// File: rtl/frac_pll_seq.sv
module frac_pll_seq
   import frac_pll_pkg::*;
#(
   parameter int unsigned RW        = 32,
   parameter int unsigned DW        = 64,
   parameter int unsigned FRAC_BITS = 18,
   parameter int unsigned SD_STEP   = 250_000_000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic [RW-1:0]        ref_in_i,
   input  logic [RW-1:0]        tgt_out_i,
   input  logic [RW-1:0]        fint_max_i,
   input  logic [RW-1:0]        dco_min_i,
   output logic                 div_start_o,
   output logic [DW-1:0]        div_dividend_o,
   output logic [DW-1:0]        div_divisor_o,
   input  logic                 div_done_i,
   input  logic [DW-1:0]        div_quot_i,
   input  logic [DW-1:0]        div_rem_i,
   output logic                 busy_o,
   output logic                 done_o,
   output logic                 err_o,
   output logic [RW-1:0]        pre_n_o,
   output logic [RW-1:0]        mult_m_o,
   output logic [FRAC_BITS-1:0] frac_o,
   output logic [RW-1:0]        post_m2_o,
   output logic [RW-1:0]        sd_o,
   output logic [RW-1:0]        fint_o,
   output logic [DW-1:0]        dco_o,
   output logic [RW-1:0]        out_o
);
   localparam int unsigned RMW = DW - FRAC_BITS;

   calc_state_e state;
   logic                 pend;
   logic [RW-1:0]        fin_q, tgt_q, fmax_q, dmin_q;
   logic [RW-1:0]        n_w, fint_w, m2_w, m_w, out_w;
   logic [DW-1:0]        mind_w, dco_int_w, dco_w;
   logic [RMW-1:0]       rem_w;
   logic [FRAC_BITS-1:0] mf_w;
   logic                 short_w;
   logic                 bad_req, frac_ovf;

   assign bad_req  = (ref_in_i == '0) || (tgt_out_i == '0) || (fint_max_i == '0);
   assign frac_ovf = |div_quot_i[DW-1:FRAC_BITS];
   assign busy_o   = (state != ST_IDLE);
   assign div_start_o = (state != ST_IDLE) && (state != ST_FIN) && !pend;

   // Operand selection for the shared divider, one pair per step.
   always_comb begin
      div_dividend_o = '0;
      div_divisor_o  = DW'(1);
      unique case (state)
         ST_PREDIV: begin
            div_dividend_o = DW'(fin_q) + DW'(fmax_q) - DW'(1);
            div_divisor_o  = DW'(fmax_q);
         end
         ST_FINT: begin
            div_dividend_o = DW'(fin_q);
            div_divisor_o  = DW'(n_w);
         end
         ST_RNDUP: begin
            div_dividend_o = DW'(dmin_q) + DW'(fint_w) - DW'(1);
            div_divisor_o  = DW'(fint_w);
         end
         ST_POST: begin
            div_dividend_o = mind_w + DW'(tgt_q) - DW'(1);
            div_divisor_o  = DW'(tgt_q);
         end
         ST_MULT: begin
            div_dividend_o = DW'(tgt_q) * DW'(m2_w);
            div_divisor_o  = DW'(fint_w);
         end
         ST_FRAC: begin
            div_dividend_o = {rem_w, {FRAC_BITS{1'b0}}};
            div_divisor_o  = DW'(fint_w);
         end
         ST_OUT: begin
            div_dividend_o = dco_w;
            div_divisor_o  = DW'(m2_w);
         end
         ST_SD: begin
            div_dividend_o = dco_int_w + DW'(SD_STEP - 1);
            div_divisor_o  = DW'(SD_STEP);
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         pend  <= 1'b0;
         {fin_q, tgt_q, fmax_q, dmin_q} <= '0;
         {n_w, fint_w, m2_w, m_w, out_w} <= '0;
         {mind_w, dco_int_w, dco_w} <= '0;
         rem_w   <= '0;
         mf_w    <= '0;
         short_w <= 1'b0;
         done_o  <= 1'b0;
         err_o   <= 1'b0;
         {pre_n_o, mult_m_o, post_m2_o, sd_o, fint_o, out_o} <= '0;
         frac_o  <= '0;
         dco_o   <= '0;
      end else begin
         done_o <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               pend <= 1'b0;
               if (start_i) begin
                  if (bad_req) begin
                     {pre_n_o, mult_m_o, post_m2_o, sd_o, fint_o, out_o} <= '0;
                     frac_o <= '0;
                     dco_o  <= '0;
                     err_o  <= 1'b1;
                     state  <= ST_FIN;
                  end else begin
                     fin_q   <= ref_in_i;
                     tgt_q   <= tgt_out_i;
                     fmax_q  <= fint_max_i;
                     dmin_q  <= dco_min_i;
                     short_w <= 1'b0;
                     state   <= ST_PREDIV;
                  end
               end
            end
            ST_FIN: begin
               done_o <= 1'b1;
               state  <= ST_IDLE;
            end
            default: begin
               if (div_start_o) pend <= 1'b1;
               if (div_done_i) begin
                  pend <= 1'b0;
                  unique case (state)
                     ST_PREDIV: begin
                        n_w   <= div_quot_i[RW-1:0];
                        state <= ST_FINT;
                     end
                     ST_FINT: begin
                        fint_w <= div_quot_i[RW-1:0];
                        state  <= ST_RNDUP;
                     end
                     ST_RNDUP: begin
                        mind_w <= DW'(div_quot_i[RW-1:0]) * DW'(fint_w);
                        state  <= ST_POST;
                     end
                     ST_POST: begin
                        m2_w  <= (div_quot_i == '0) ? RW'(1) : div_quot_i[RW-1:0];
                        state <= ST_MULT;
                     end
                     ST_MULT: begin
                        m_w       <= div_quot_i[RW-1:0];
                        dco_int_w <= DW'(div_quot_i[RW-1:0]) * DW'(fint_w);
                        rem_w     <= div_rem_i[RMW-1:0];
                        short_w   <= (div_rem_i > DW'(fint_w));
                        state     <= ST_FRAC;
                     end
                     ST_FRAC: begin
                        if (short_w || frac_ovf) begin
                           mf_w    <= '0;
                           short_w <= 1'b1;
                           dco_w   <= dco_int_w;
                        end else begin
                           mf_w  <= div_quot_i[FRAC_BITS-1:0];
                           dco_w <= dco_int_w +
                              ((DW'(div_quot_i[FRAC_BITS-1:0]) * DW'(fint_w)) >> FRAC_BITS);
                        end
                        state <= ST_OUT;
                     end
                     ST_OUT: begin
                        out_w <= div_quot_i[RW-1:0];
                        state <= ST_SD;
                     end
                     ST_SD: begin
                        pre_n_o   <= n_w;
                        mult_m_o  <= m_w;
                        frac_o    <= mf_w;
                        post_m2_o <= m2_w;
                        sd_o      <= div_quot_i[RW-1:0];
                        fint_o    <= fint_w;
                        dco_o     <= dco_w;
                        out_o     <= out_w;
                        err_o     <= short_w;
                        state     <= ST_FIN;
                     end
                     default: state <= ST_IDLE;
                  endcase
               end
            end
         endcase
      end
   end

   p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);
   p_opnd_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> ($stable(fin_q) && $stable(tgt_q) && $stable(fmax_q) && $stable(dmin_q)));
   p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> ($stable(pre_n_o) && $stable(dco_o) && $stable(out_o) && $stable(frac_o)));
   p_post_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !err_o) |-> (post_m2_o != '0));
   p_err_zeroes_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && err_o) |-> (pre_n_o == '0 && post_m2_o == '0 && dco_o == '0));

endmodule

// File: rtl/frac_pll_calc.sv
module frac_pll_calc #(
   parameter int unsigned RW        = 32,
   parameter int unsigned DW        = 64,
   parameter int unsigned FRAC_BITS = 18,
   parameter int unsigned SD_STEP   = 250_000_000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic [RW-1:0]        ref_in_i,
   input  logic [RW-1:0]        tgt_out_i,
   input  logic [RW-1:0]        fint_max_i,
   input  logic [RW-1:0]        dco_min_i,
   output logic                 busy_o,
   output logic                 done_o,
   output logic                 err_o,
   output logic [RW-1:0]        pre_n_o,
   output logic [RW-1:0]        mult_m_o,
   output logic [FRAC_BITS-1:0] frac_o,
   output logic [RW-1:0]        post_m2_o,
   output logic [RW-1:0]        sd_o,
   output logic [RW-1:0]        fint_o,
   output logic [DW-1:0]        dco_o,
   output logic [RW-1:0]        out_o
);
   generate
      if (DW < 2 * RW) begin : g_bad_width
         $error("divider width must hold a product of two rates");
      end
      if (FRAC_BITS >= RW) begin : g_bad_frac
         $error("fraction field must be narrower than a rate");
      end
      if (DW < RW + FRAC_BITS) begin : g_bad_frac_path
         $error("divider width too small for the fraction dividend");
      end
   endgenerate

   logic          dv_start, dv_done, dv_busy;
   logic [DW-1:0] dv_dividend, dv_divisor, dv_quot, dv_rem;

   frac_pll_divider #(.DW(DW)) u_div (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (dv_start),
      .dividend_i (dv_dividend),
      .divisor_i  (dv_divisor),
      .busy_o     (dv_busy),
      .done_o     (dv_done),
      .quot_o     (dv_quot),
      .rem_o      (dv_rem)
   );

   frac_pll_seq #(
      .RW(RW), .DW(DW), .FRAC_BITS(FRAC_BITS), .SD_STEP(SD_STEP)
   ) u_seq (
      .clk            (clk),
      .rst_n          (rst_n),
      .start_i        (start_i),
      .ref_in_i       (ref_in_i),
      .tgt_out_i      (tgt_out_i),
      .fint_max_i     (fint_max_i),
      .dco_min_i      (dco_min_i),
      .div_start_o    (dv_start),
      .div_dividend_o (dv_dividend),
      .div_divisor_o  (dv_divisor),
      .div_done_i     (dv_done),
      .div_quot_i     (dv_quot),
      .div_rem_i      (dv_rem),
      .busy_o         (busy_o),
      .done_o         (done_o),
      .err_o          (err_o),
      .pre_n_o        (pre_n_o),
      .mult_m_o       (mult_m_o),
      .frac_o         (frac_o),
      .post_m2_o      (post_m2_o),
      .sd_o           (sd_o),
      .fint_o         (fint_o),
      .dco_o          (dco_o),
      .out_o          (out_o)
   );

   // The shared divider never runs while the sequencer is idle.
   p_div_quiet_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !dv_busy);
   // The divider is never restarted in the middle of a run.
   p_div_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      dv_busy |-> !dv_start);

endmodule

// File: tb/frac_pll_calc_tb.sv
module frac_pll_calc_tb;
   localparam int LAT = 8 * (64 + 2) + 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [31:0] ref_in_i = '0, tgt_out_i = '0, fint_max_i = '0, dco_min_i = '0;
   logic        busy_o, done_o, err_o;
   logic [31:0] pre_n_o, mult_m_o, post_m2_o, sd_o, fint_o, out_o;
   logic [17:0] frac_o;
   logic [63:0] dco_o;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   frac_pll_calc u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .ref_in_i(ref_in_i), .tgt_out_i(tgt_out_i),
      .fint_max_i(fint_max_i), .dco_min_i(dco_min_i),
      .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
      .pre_n_o(pre_n_o), .mult_m_o(mult_m_o), .frac_o(frac_o),
      .post_m2_o(post_m2_o), .sd_o(sd_o), .fint_o(fint_o),
      .dco_o(dco_o), .out_o(out_o)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // Expected settings straight from the requirement formulas.
   logic [127:0] e_n, e_fint, e_m2, e_m, e_mf, e_sd, e_dco, e_out;
   logic         e_err;

   task automatic model(input logic [127:0] fin, tgt, fmax, dmin);
      logic [127:0] mind, tdco, rem;
      if (fin == 0 || tgt == 0 || fmax == 0) begin
         e_n = 0; e_fint = 0; e_m2 = 0; e_m = 0; e_mf = 0;
         e_sd = 0; e_dco = 0; e_out = 0; e_err = 1'b1;
      end else begin
         e_err  = 1'b0;
         e_n    = (fin + fmax - 1) / fmax;                    // R1
         e_fint = fin / e_n;
         mind   = ((dmin + e_fint - 1) / e_fint) * e_fint;    // R2
         e_m2   = (mind + tgt - 1) / tgt;
         if (e_m2 == 0) e_m2 = 1;
         tdco   = tgt * e_m2;                                 // R3
         e_m    = tdco / e_fint;
         rem    = tdco - e_fint * e_m;
         if (rem > e_fint) begin e_mf = 0; e_err = 1'b1; end
         else e_mf = (rem * 262144) / e_fint;
         e_dco  = e_fint * e_m + (e_mf * e_fint) / 262144;    // R4
         e_out  = e_dco / e_m2;
         e_sd   = (e_fint * e_m + 249999999) / 250000000;     // R5
      end
   endtask

   task automatic check_results(input string tag);
      check({"R1 predivider ", tag}, 64'(pre_n_o), e_n[63:0]);
      check({"R1 internal rate ", tag}, 64'(fint_o), e_fint[63:0]);
      check({"R2 post-divider ", tag}, 64'(post_m2_o), e_m2[63:0]);
      check({"R3 multiplier ", tag}, 64'(mult_m_o), e_m[63:0]);
      check({"R3 fraction ", tag}, 64'(frac_o), e_mf[63:0]);
      check({"R4 oscillator ", tag}, dco_o, e_dco[63:0]);
      check({"R4 output rate ", tag}, 64'(out_o), e_out[63:0]);
      check({"R5 sigma-delta ", tag}, 64'(sd_o), e_sd[63:0]);
      check({"R9 error flag ", tag}, 64'(err_o), 64'(e_err));
   endtask

   task automatic run_case(input string tag, input logic [31:0] fin, tgt, fmax, dmin,
                           input bit inject);
      int lat;
      model(fin, tgt, fmax, dmin);
      lat = (fin == 0 || tgt == 0 || fmax == 0) ? 1 : LAT;
      @(negedge clk);
      ref_in_i = fin; tgt_out_i = tgt; fint_max_i = fmax; dco_min_i = dmin;
      start_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      check({"R6 busy after accept ", tag}, 64'(busy_o), 64'd1);
      check({"R6 no early done ", tag}, 64'(done_o), 64'd0);
      for (int k = 1; k <= lat; k++) begin
         @(negedge clk);
         start_i = 1'b0;
         check({"R6 done timing ", tag}, 64'(done_o), 64'(k == lat));
         check({"R6 busy timing ", tag}, 64'(busy_o), 64'(k < lat));
         if (inject && k == 100) begin
            // R7: stray request during a run, different operands.
            ref_in_i = 32'd27_000_000; tgt_out_i = 32'd33_000_000;
            fint_max_i = 32'd900_000; dco_min_i = 32'd10_000;
            start_i = 1'b1;
         end
      end
      check_results({tag, inject ? " R7 after stray start" : ""});
      for (int j = 0; j < 20; j++) begin
         @(negedge clk);
         check({"R8 no repeat done ", tag}, 64'(done_o), 64'd0);
      end
      check_results({tag, " R8 held"});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      check("R10 busy", 64'(busy_o), 64'd0);
      check("R10 done", 64'(done_o), 64'd0);
      check("R10 err", 64'(err_o), 64'd0);
      check("R10 predivider", 64'(pre_n_o), 64'd0);
      check("R10 oscillator", dco_o, 64'd0);
      check("R10 fraction", 64'(frac_o), 64'd0);
      check("R10 output rate", 64'(out_o), 64'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      run_case("typical", 32'd19_200_000, 32'd148_500_000, 32'd2_500_000, 32'd500_000_000, 1'b0);
      run_case("exact ratio", 32'd20_000_000, 32'd100_000_000, 32'd2_000_000, 32'd1_000_000_000, 1'b0);
      run_case("R2 zero minimum", 32'd1_000_000, 32'd25_000_000, 32'd2_500_000, 32'd0, 1'b0);
      run_case("R7 stray", 32'd38_400_000, 32'd74_250_000, 32'd2_100_000, 32'd750_000_000, 1'b1);
      run_case("high oscillator", 32'd26_000_000, 32'd297_000_000, 32'd1_300_000, 32'd2_000_000_000, 1'b0);
      run_case("R9 zero target", 32'd19_200_000, 32'd0, 32'd2_500_000, 32'd500_000_000, 1'b0);
      run_case("R9 zero max", 32'd19_200_000, 32'd148_500_000, 32'd0, 32'd500_000_000, 1'b0);
      run_case("R9 zero reference", 32'd0, 32'd148_500_000, 32'd2_500_000, 32'd500_000_000, 1'b0);
      run_case("error cleared", 32'd12_000_000, 32'd65_000_000, 32'd1_000_000, 32'd800_000_000, 1'b0);

      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog R6 actual=hung expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule